// File: doc/BRIEF.md
# Scaler Coefficient Memory Access Port

This block sits on the configuration side of a video scaler and owns the filter coefficient storage. A DMA-driven control bus writes coefficients one 128-bit quad-word at a time. A debug path reads them back one 32-bit word at a time. The quad-word write index and the word read address both select a coefficient region and a row. The regions are horizontal luma, horizontal chroma, vertical luma and vertical chroma. The vertical filter also has separate top-field and bottom-field luma and chroma banks.

The coefficient storage has no shadow copy, so it must not change while the scaler is filtering a frame. The write port is valid/ready. The scaler reports its progress on two plain inputs: a frame-active level and a last-output-beat pulse. Once a frame starts, the block drops ready and holds it low until the last output beat of that frame has been seen. A stalled write is therefore delayed and never lost. The source must keep valid asserted, with address and data stable, until ready is seen high at a clock edge. Ready does not depend combinationally on valid. The read port has no back-pressure: it accepts an address on any cycle, including during a frame, and answers exactly one cycle later.

Top module: `coef_mem_port`

## Requirements
- R1: A write transfers on a rising clock edge where both `wr_valid` and `wr_ready` are high. The quad-word at index `wr_qaddr` then holds `wr_data`, with word lane k taken from bits 32k+31 down to 32k (lane 0 = bits 31:0, lane 3 = bits 127:96).
- R2: The quad-word index is decoded as region = bits 7:5 and row = bits 4:0, with 32 rows per region. Regions 0 to 7 are, in order: horizontal luma, horizontal chroma, vertical luma, vertical chroma, top-field luma, top-field chroma, bottom-field luma, bottom-field chroma.
- R3: A read address is accepted on any edge where `rd_en` is high. The read word address equals quad-word index × 4 + lane. The cycle after acceptance, `rd_valid` is high and `rd_data` holds that word. `rd_valid` is low in every other cycle.
- R4: The top-field and bottom-field vertical banks are separate storage. A write to one leaves the other unchanged, and each can be read on its own.
- R5: If `frame_active` is high and `frame_last` is low at an edge, `wr_ready` is low after that edge. It stays low until a `frame_last` pulse. A write offered meanwhile is not performed and does not alter the storage.
- R6: If `frame_last` is high at an edge, `wr_ready` is high after that edge. A write held pending through the stall completes at the first edge that has `wr_ready` high.
- R7: Reads are served during a frame stall and never change the stored coefficients.
- R8: With `FULL_VERTICAL` = 0, only regions 0 to 3 exist. A read at word address 512 or above returns zero with `rd_err` high. A write to quad-word index 128 or above is accepted and discarded. With `FULL_VERTICAL` = 1, `rd_err` is always low.
- R9: After reset, `wr_ready` is high, `rd_valid` is low and every stored word reads as zero.
- R10: A read and a write to the same quad-word at the same edge return the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_active | input | 1 | Scaler is processing a frame |
| frame_last | input | 1 | Pulse: last output beat of the frame leaves the scaler |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write can be accepted at this edge |
| wr_qaddr | input | 8 | Quad-word index (region, row) |
| wr_data | input | 128 | Quad-word coefficient data |
| rd_en | input | 1 | Read request (always accepted) |
| rd_waddr | input | 10 | Word read address |
| rd_valid | output | 1 | Read data valid (one cycle after request) |
| rd_data | output | 32 | Read word |
| rd_err | output | 1 | Read hit an absent region |

## Verification
The assertions check on every cycle that ready drops after a frame starts and returns after the last-beat pulse. They also check that the source holds a stalled write steady, that read responses follow requests by exactly one cycle, and that absent regions return zero. Their error flag must stay low in the full configuration. Only the bench scenarios can show that data lands in the right region, row and lane, and that the top-field and bottom-field banks do not alias. The same applies to a stalled write being delayed rather than dropped, to reads leaving contents untouched, and to the reduced configuration discarding high writes instead of wrapping them.

// File: rtl/coef_port_pkg.sv
package coef_port_pkg;
  localparam int WORD_W     = 32;
  localparam int LANES      = 4;
  localparam int LANE_W     = $clog2(LANES);
  localparam int QW_W       = WORD_W * LANES;
  localparam int REGION_MAX = 8;
  localparam int REGION_W   = $clog2(REGION_MAX);

  typedef enum logic [REGION_W-1:0] {
    RG_H_LUMA    = 3'd0,
    RG_H_CHROMA  = 3'd1,
    RG_V_LUMA    = 3'd2,
    RG_V_CHROMA  = 3'd3,
    RG_VT_LUMA   = 3'd4,
    RG_VT_CHROMA = 3'd5,
    RG_VB_LUMA   = 3'd6,
    RG_VB_CHROMA = 3'd7
  } region_e;
endpackage

// File: rtl/coef_wr_gate.sv
module coef_wr_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_active,
  input  logic frame_last,
  input  logic wr_valid,
  output logic wr_ready,
  output logic wr_fire
);
  logic stall_q;

  // The last-beat pulse wins over frame_active sampled on the same edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            stall_q <= 1'b0;
    else if (frame_last)   stall_q <= 1'b0;
    else if (frame_active) stall_q <= 1'b1;
  end

  assign wr_ready = !stall_q;
  assign wr_fire  = wr_valid && !stall_q;

  p_stall_after_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_active && !frame_last) |=> !wr_ready);

  p_release_on_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_last |=> wr_ready);
endmodule

// File: rtl/coef_rd_decode.sv
module coef_rd_decode
  import coef_port_pkg::*;
#(
  parameter int ROWS        = 32,
  parameter int NUM_REGIONS = 8,
  localparam int ROW_W      = $clog2(ROWS),
  localparam int RA_W       = REGION_W + ROW_W + LANE_W
) (
  input  logic [RA_W-1:0]   waddr,
  output region_e           region,
  output logic [ROW_W-1:0]  row,
  output logic [LANE_W-1:0] lane,
  output logic              mapped
);
  assign lane   = waddr[LANE_W-1:0];
  assign row    = waddr[LANE_W +: ROW_W];
  assign region = region_e'(waddr[RA_W-1 -: REGION_W]);
  assign mapped = int'(waddr[RA_W-1 -: REGION_W]) < NUM_REGIONS;
endmodule

// File: rtl/coef_bank.sv
module coef_bank
  import coef_port_pkg::*;
#(
  parameter int ROWS   = 32,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ROW_W-1:0]  wr_row,
  input  logic [QW_W-1:0]   wr_data,
  input  logic [ROW_W-1:0]  rd_row,
  input  logic [LANE_W-1:0] rd_lane,
  output logic [WORD_W-1:0] rd_word
);
  logic [QW_W-1:0] mem [ROWS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ROWS; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_row] <= wr_data;
    end
  end

  always_comb begin
    rd_word = '0;
    for (int k = 0; k < LANES; k++) begin
      if (int'(rd_lane) == k) rd_word = mem[rd_row][k*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/coef_mem_port.sv
module coef_mem_port
  import coef_port_pkg::*;
#(
  parameter int ROWS          = 32,
  parameter bit FULL_VERTICAL = 1'b1
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     frame_active,
  input  logic                                     frame_last,
  input  logic                                     wr_valid,
  output logic                                     wr_ready,
  input  logic [coef_port_pkg::REGION_W+$clog2(ROWS)-1:0] wr_qaddr,
  input  logic [coef_port_pkg::QW_W-1:0]           wr_data,
  input  logic                                     rd_en,
  input  logic [coef_port_pkg::REGION_W+$clog2(ROWS)+coef_port_pkg::LANE_W-1:0] rd_waddr,
  output logic                                     rd_valid,
  output logic [coef_port_pkg::WORD_W-1:0]         rd_data,
  output logic                                     rd_err
);
  localparam int ROW_W       = $clog2(ROWS);
  localparam int QA_W        = REGION_W + ROW_W;
  localparam int NUM_REGIONS = FULL_VERTICAL ? REGION_MAX : REGION_MAX / 2;

  logic wr_fire;

  coef_wr_gate u_gate (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_active (frame_active),
    .frame_last   (frame_last),
    .wr_valid     (wr_valid),
    .wr_ready     (wr_ready),
    .wr_fire      (wr_fire)
  );

  // Write index: upper bits pick the region, lower bits the row.
  logic [REGION_W-1:0] wr_region;
  logic [ROW_W-1:0]    wr_row;
  logic                wr_mapped;
  assign wr_region = wr_qaddr[QA_W-1 -: REGION_W];
  assign wr_row    = wr_qaddr[ROW_W-1:0];
  assign wr_mapped = int'(wr_region) < NUM_REGIONS;

  region_e             rd_region;
  logic [ROW_W-1:0]    rd_row;
  logic [LANE_W-1:0]   rd_lane;
  logic                rd_mapped;

  coef_rd_decode #(.ROWS(ROWS), .NUM_REGIONS(NUM_REGIONS)) u_rd_dec (
    .waddr  (rd_waddr),
    .region (rd_region),
    .row    (rd_row),
    .lane   (rd_lane),
    .mapped (rd_mapped)
  );

  logic [WORD_W-1:0] bank_word [NUM_REGIONS];

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_bank
    logic bank_wr;
    assign bank_wr = wr_fire && wr_mapped && (int'(wr_region) == g);
    coef_bank #(.ROWS(ROWS)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bank_wr),
      .wr_row  (wr_row),
      .wr_data (wr_data),
      .rd_row  (rd_row),
      .rd_lane (rd_lane),
      .rd_word (bank_word[g])
    );
  end

  logic [WORD_W-1:0] rd_sel;
  always_comb begin
    rd_sel = '0;
    for (int g = 0; g < NUM_REGIONS; g++) begin
      if (rd_mapped && int'(rd_region) == g) rd_sel = bank_word[g];
    end
  end

  // Registered read: sampled before any same-edge write lands.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_err   <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        rd_data <= rd_sel;
        rd_err  <= !rd_mapped;
      end else begin
        rd_err  <= 1'b0;
      end
    end
  end

  p_rd_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  p_rd_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

  p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_err) |-> (rd_data == '0));

  p_wr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_qaddr) && $stable(wr_data)));

  if (FULL_VERTICAL) begin : g_full_chk
    p_full_no_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> !rd_err);
  end
endmodule

// File: tb/coef_mem_port_bench.sv
module coef_mem_port_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic         frame_active = 0, frame_last = 0, wr_valid = 0, rd_en = 0;
  logic [7:0]   wr_qaddr = '0;
  logic [127:0] wr_data = '0;
  logic [9:0]   rd_waddr = '0;
  logic         wr_ready_f, rd_valid_f, rd_err_f;
  logic         wr_ready_r, rd_valid_r, rd_err_r;
  logic [31:0]  rd_data_f, rd_data_r;

  int checks = 0, errors = 0;
  bit done = 0;

  coef_mem_port #(.ROWS(32), .FULL_VERTICAL(1'b1)) u_coef_mem_port (
    .clk(clk), .rst_n(rst_n), .frame_active(frame_active), .frame_last(frame_last),
    .wr_valid(wr_valid), .wr_ready(wr_ready_f), .wr_qaddr(wr_qaddr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_waddr(rd_waddr), .rd_valid(rd_valid_f), .rd_data(rd_data_f),
    .rd_err(rd_err_f));

  coef_mem_port #(.ROWS(32), .FULL_VERTICAL(1'b0)) u_coef_mem_port_reduced (
    .clk(clk), .rst_n(rst_n), .frame_active(frame_active), .frame_last(frame_last),
    .wr_valid(wr_valid), .wr_ready(wr_ready_r), .wr_qaddr(wr_qaddr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_waddr(rd_waddr), .rd_valid(rd_valid_r), .rd_data(rd_data_r),
    .rd_err(rd_err_r));

  function automatic logic [31:0] pat(int q, int lane, int seed);
    return {8'(seed), 8'(q), 8'(lane), 8'(q * 3 + lane + seed * 7)};
  endfunction

  function automatic logic [127:0] qpat(int q, int seed);
    logic [127:0] d;
    for (int k = 0; k < 4; k++) d[k*32 +: 32] = pat(q, k, seed);
    return d;
  endfunction

  task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(int q, int seed);
    @(negedge clk);
    wr_valid = 1; wr_qaddr = 8'(q); wr_data = qpat(q, seed);
    while (!wr_ready_f) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    wr_valid = 0;
  endtask

  // Returns values seen one cycle after the request, away from the edge.
  task automatic do_read(int w, output logic [31:0] df, output logic ef, output logic vf,
                         output logic [31:0] dr, output logic er);
    @(negedge clk);
    rd_en = 1; rd_waddr = 10'(w);
    @(posedge clk);
    @(negedge clk);
    rd_en = 0;
    df = rd_data_f; ef = rd_err_f; vf = rd_valid_f; dr = rd_data_r; er = rd_err_r;
  endtask

  task automatic t_reset();
    logic [31:0] df, dr; logic ef, vf, er;
    @(negedge clk);
    chk(wr_ready_f == 1, "R9 ready after reset", 128'(wr_ready_f), 1);
    chk(rd_valid_f == 0, "R9 rd_valid after reset", 128'(rd_valid_f), 0);
    do_read(77, df, ef, vf, dr, er);
    chk(df == 0 && ef == 0, "R9 zero contents", 128'(df), 0);
    @(negedge clk);
    chk(rd_valid_f == 0, "R3 rd_valid single cycle", 128'(rd_valid_f), 0);
  endtask

  task automatic t_fill_and_read();
    logic [31:0] df, dr; logic ef, vf, er;
    for (int q = 0; q < 256; q++) do_write(q, 1);
    for (int w = 0; w < 1024; w++) begin
      do_read(w, df, ef, vf, dr, er);
      chk(vf == 1 && df == pat(w / 4, w % 4, 1) && ef == 0,
          "R1 R2 R3 full readback", 128'(df), 128'(pat(w / 4, w % 4, 1)));
      if (w < 512)
        chk(dr == pat(w / 4, w % 4, 1) && er == 0, "R8 reduced mapped readback",
            128'(dr), 128'(pat(w / 4, w % 4, 1)));
      else
        chk(dr == 0 && er == 1, "R8 reduced unmapped read", {95'(0), er, dr}, {95'(0), 1'b1, 32'h0});
    end
  endtask

  task automatic t_field_banks();
    logic [31:0] df, dr; logic ef, vf, er;
    do_write(4 * 32 + 5, 2);
    do_read((4 * 32 + 5) * 4 + 2, df, ef, vf, dr, er);
    chk(df == pat(133, 2, 2), "R4 top-field bank written", 128'(df), 128'(pat(133, 2, 2)));
    do_read((6 * 32 + 5) * 4 + 2, df, ef, vf, dr, er);
    chk(df == pat(197, 2, 1), "R4 bottom-field bank untouched", 128'(df), 128'(pat(197, 2, 1)));
    do_read((2 * 32 + 5) * 4 + 2, df, ef, vf, dr, er);
    chk(df == pat(69, 2, 1), "R4 vertical luma untouched", 128'(df), 128'(pat(69, 2, 1)));
  endtask

  task automatic t_stall();
    logic [31:0] df, dr; logic ef, vf, er;
    @(negedge clk);
    frame_active = 1;
    @(negedge clk);
    wr_valid = 1; wr_qaddr = 8'd33; wr_data = qpat(33, 4);
    chk(wr_ready_f == 0, "R5 ready low in frame", 128'(wr_ready_f), 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(wr_ready_f == 0, "R5 ready held low", 128'(wr_ready_f), 0);
    end
    do_read(33 * 4 + 1, df, ef, vf, dr, er);
    chk(df == pat(33, 1, 1), "R5 R7 stalled write not applied, read in frame",
        128'(df), 128'(pat(33, 1, 1)));
    chk(wr_ready_f == 0, "R5 ready still low", 128'(wr_ready_f), 0);
    frame_active = 0; frame_last = 1;
    @(negedge clk);
    frame_last = 0;
    chk(wr_ready_f == 1, "R6 ready after last beat", 128'(wr_ready_f), 1);
    @(negedge clk);
    wr_valid = 0;
    for (int k = 0; k < 4; k++) begin
      do_read(33 * 4 + k, df, ef, vf, dr, er);
      chk(df == pat(33, k, 4), "R6 stalled write completed", 128'(df), 128'(pat(33, k, 4)));
    end
    do_read(34 * 4, df, ef, vf, dr, er);
    chk(df == pat(34, 0, 1), "R7 neighbour untouched", 128'(df), 128'(pat(34, 0, 1)));
  endtask

  task automatic t_same_cycle();
    logic [31:0] df, dr; logic ef, vf, er;
    @(negedge clk);
    wr_valid = 1; wr_qaddr = 8'd10; wr_data = qpat(10, 3);
    rd_en = 1; rd_waddr = 10'd40;
    @(posedge clk);
    @(negedge clk);
    wr_valid = 0; rd_en = 0;
    chk(rd_data_f == pat(10, 0, 1), "R10 old data on collision", 128'(rd_data_f), 128'(pat(10, 0, 1)));
    do_read(41, df, ef, vf, dr, er);
    chk(df == pat(10, 1, 3), "R10 new data after collision", 128'(df), 128'(pat(10, 1, 3)));
    chk(dr == pat(10, 1, 3), "R1 reduced lane 1", 128'(dr), 128'(pat(10, 1, 3)));
  endtask

  task automatic t_reduced_discard();
    logic [31:0] df, dr; logic ef, vf, er;
    do_write(128, 5);
    do_read(0, df, ef, vf, dr, er);
    chk(dr == pat(0, 0, 1) && er == 0, "R8 high write discarded in reduced", 128'(dr), 128'(pat(0, 0, 1)));
    do_read(512 + 3, df, ef, vf, dr, er);
    chk(df == pat(128, 3, 5), "R8 full config keeps region 4", 128'(df), 128'(pat(128, 3, 5)));
    chk(dr == 0 && er == 1, "R8 reduced unmapped read after write", 128'(dr), 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_fill_and_read();
    t_field_banks();
    t_stall();
    t_same_cycle();
    t_reduced_discard();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule